// File: doc/BRIEF.md
# Refresh-Counter Test Sequencer for an Asynchronous DRAM

This block is the strobe-sequence logic of an asynchronous DRAM. It watches the row strobe, two column strobes (lower and upper byte), the write enable, the output enable and a nine-bit multiplexed address bus. All of these inputs are active low. The block samples them on a fast internal clock.

It sorts each row-strobe-low period into one of three kinds:
- a normal access, where the row comes from the pins;
- a RAS-only refresh;
- a CAS-before-RAS (CBR) refresh, which uses an internal nine-bit row counter.

A CBR refresh can become a counter test access. This happens when a column strobe falls a second time while the row strobe is still low. The test access takes its row from the refresh counter and its column from the pins at that edge. This lets the whole counter be walked and checked through ordinary reads and writes.

The block drives the active row and column, single-cycle read and write strobes toward the array, and a data-output enable. The storage array is not part of the block.

Top module: `cbr_refresh_ctl`

## Requirements
- R1: After reset the refresh counter is 0, the sequencer is idle, rowAddr and colAddr are 0, and rdStb, wrStb and dqOe are 0.
- R2: A row-strobe fall while a column strobe is low starts a CBR refresh. That cycle issues no strobe. The counter rises by one when the row strobe returns high, and the next CBR cycle uses the new value as its row.
- R3: For CBR detection and for every column edge, either column strobe counts. The column strobe is taken as low when lcasN or ucasN is low.
- R4: The refresh counter wraps from 511 to 0.
- R5: In a CBR cycle, a new column-strobe fall while the row strobe is low opens a test access. Its row is the counter value and its column is the addr value at that fall. rowAddr and colAddr show these one clock after the fall is sampled.
- R6: At an access-opening column fall, weN low gives a one-clock wrStb pulse and weN high gives a one-clock rdStb pulse. Both appear one clock after the fall.
- R7: dqOe is 1 only while a read access is open, rasN is 0, a column strobe is low and oeN is 0. Otherwise it is 0.
- R8: A row-strobe-low period with the column strobe high at the row fall and no column fall before the row strobe rises is a RAS-only refresh. It clears the counter to 0.
- R9: A row fall with the column strobe high latches the row from addr. A later column fall latches the column and issues an access, and the counter is left unchanged.
- R10: Further column-strobe falls in the same row-strobe-low period each issue a new access with a freshly latched column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Lower-byte column strobe, active low |
| ucasN | input | 1 | Upper-byte column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| rowAddr | output | ADDR_W | Active row toward the array |
| colAddr | output | ADDR_W | Active column toward the array |
| rdStb | output | 1 | One-clock read strobe |
| wrStb | output | 1 | One-clock write strobe |
| dqOe | output | 1 | Data-output enable |

## Verification
The bench first normalises the counter with eight RAS-only cycles. It then writes a constant through 512 CBR test accesses, reads and inverts each row with normal cycles, reads all rows again through CBR test accesses, and repeats the whole sequence with inverted data. A wrong row from the counter, a missed wrap or a lost increment shows up as a data mismatch against the behavioural memory.

Directed cycles separate the remaining cases:
- upper-strobe-only CBR cycles against lower-strobe ones;
- a RAS-only cycle placed in the middle of a count;
- page-mode column falls;
- reads held with the output enable high, which shows whether dqOe is gated.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CBR,
    ST_TEST
  } seqState_t;

  typedef struct packed {
    logic latchRowPins;
    logic latchRowCnt;
    logic issue;
    logic isWrite;
    logic cntInc;
    logic cntClr;
    logic endCycle;
  } dpStrobe_t;

endpackage

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casLow,
  input  logic       weN,
  output dpStrobe_t  stb
);

  seqState_t state, stateNext;
  logic      casLowPrev;
  logic      casFall;

  assign casFall = casLow & ~casLowPrev;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (state == ST_IDLE) begin
      if (!rasN) begin
        if (casLow) begin
          stateNext       = ST_CBR;
          stb.latchRowCnt = 1'b1;
        end else begin
          stateNext        = ST_ROW;
          stb.latchRowPins = 1'b1;
        end
      end
    end else if (rasN) begin
      stateNext    = ST_IDLE;
      stb.endCycle = 1'b1;
      stb.cntClr   = (state == ST_ROW);
      stb.cntInc   = (state == ST_CBR) || (state == ST_TEST);
    end else if (casFall) begin
      stb.issue   = 1'b1;
      stb.isWrite = ~weN;
      if (state == ST_ROW) stateNext = ST_COL;
      if (state == ST_CBR) stateNext = ST_TEST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      casLowPrev <= 1'b0;
    end else begin
      state      <= stateNext;
      casLowPrev <= casLow;
    end
  end

endmodule

// File: rtl/cbr_refresh_dp.sv
module cbr_refresh_dp
  import cbr_refresh_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rasN,
  input  logic              casLow,
  input  logic              oeN,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              rdStb,
  output logic              wrStb,
  output logic              dqOe,
  output logic [ADDR_W-1:0] refCnt
);

  localparam logic [ADDR_W-1:0] CNT_ONE = ADDR_W'(1);

  logic readOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt   <= '0;
      rowAddr  <= '0;
      colAddr  <= '0;
      rdStb    <= 1'b0;
      wrStb    <= 1'b0;
      readOpen <= 1'b0;
    end else begin
      rdStb <= stb.issue & ~stb.isWrite;
      wrStb <= stb.issue & stb.isWrite;
      if (stb.cntClr)      refCnt <= '0;
      else if (stb.cntInc) refCnt <= refCnt + CNT_ONE;
      if (stb.latchRowPins)     rowAddr <= addr;
      else if (stb.latchRowCnt) rowAddr <= refCnt;
      if (stb.issue) begin
        colAddr  <= addr;
        readOpen <= ~stb.isWrite;
      end else if (stb.endCycle) begin
        readOpen <= 1'b0;
      end
    end
  end

  assign dqOe = readOpen & ~rasN & casLow & ~oeN;

endmodule

// File: rtl/cbr_refresh_ctl.sv
module cbr_refresh_ctl
  import cbr_refresh_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              lcasN,
  input  logic              ucasN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              rdStb,
  output logic              wrStb,
  output logic              dqOe
);

  dpStrobe_t         stb;
  logic              casLow;
  logic [ADDR_W-1:0] refCnt;

  // R3: either byte strobe low counts as column strobe low
  assign casLow = ~lcasN | ~ucasN;

  cbr_refresh_seq u_seq (
    .clk    (clk),
    .rstN   (rstN),
    .rasN   (rasN),
    .casLow (casLow),
    .weN    (weN),
    .stb    (stb)
  );

  cbr_refresh_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (addr),
    .rasN    (rasN),
    .casLow  (casLow),
    .oeN     (oeN),
    .rowAddr (rowAddr),
    .colAddr (colAddr),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .dqOe    (dqOe),
    .refCnt  (refCnt)
  );

endmodule

// File: rtl/cbr_refresh_ctl_chk.sv
module cbr_refresh_ctl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              lcasN,
  input logic              ucasN,
  input logic              oeN,
  input logic              rdStb,
  input logic              wrStb,
  input logic              dqOe,
  input logic [ADDR_W-1:0] refCnt
);

  p_oe_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!rasN && (!lcasN || !ucasN) && !oeN));

  p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));

  p_rd_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> !rdStb);

  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  p_access_in_ras_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb || wrStb) |-> $past(!rasN));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt != $past(refCnt)) |->
      ((refCnt == ADDR_W'($past(refCnt) + 1'b1)) || (refCnt == '0)));

  p_cnt_on_ras_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt != $past(refCnt)) |-> ($past(rasN) && $past(!rasN, 2)));

endmodule

bind cbr_refresh_ctl cbr_refresh_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rasN   (rasN),
  .lcasN  (lcasN),
  .ucasN  (ucasN),
  .oeN    (oeN),
  .rdStb  (rdStb),
  .wrStb  (wrStb),
  .dqOe   (dqOe),
  .refCnt (refCnt)
);

// File: tb/cbr_refresh_ctl_tb.sv
module cbr_refresh_ctl_tb;

  localparam int AW   = 9;
  localparam int ROWS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, lcasN = 1'b1, ucasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] rowAddr, colAddr;
  logic rdStb, wrStb, dqOe;

  always #2.5 clk = ~clk;

  cbr_refresh_ctl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .rowAddr(rowAddr), .colAddr(colAddr),
    .rdStb(rdStb), .wrStb(wrStb), .dqOe(dqOe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural memory (one column) and data bit under test
  bit mem [ROWS];
  bit din = 0;
  bit expBit = 0;
  bit expValid = 0;

  always @(posedge clk) if (rstN && wrStb) mem[rowAddr] <= din;

  // cycle reference model
  int  mPhase = 0;   // 0 idle,1 row open,2 cbr,3 normal access,4 test access
  int  mCnt = 0, mRow = 0, mCol = 0;
  bit  mRd = 0, mWr = 0, mOpenRd = 0, mCasPrev = 0;

  always @(posedge clk) begin
    bit casL;
    casL = !lcasN || !ucasN;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mRow = 0; mCol = 0;
      mRd = 0; mWr = 0; mOpenRd = 0; mCasPrev = 0;
    end else begin
      mRd = 0; mWr = 0;
      if (mPhase == 0) begin
        if (!rasN) begin
          if (casL) begin mPhase = 2; mRow = mCnt; end
          else begin mPhase = 1; mRow = int'(addr); end
        end
      end else if (rasN) begin
        if (mPhase == 1) mCnt = 0;
        if (mPhase == 2 || mPhase == 4) mCnt = (mCnt + 1) % ROWS;
        mPhase = 0; mOpenRd = 0;
      end else if (casL && !mCasPrev) begin
        mCol = int'(addr);
        if (weN) begin mRd = 1; mOpenRd = 1; end
        else begin mWr = 1; mOpenRd = 0; end
        if (mPhase == 1) mPhase = 3;
        if (mPhase == 2) mPhase = 4;
      end
      mCasPrev = casL;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expOe;
      expOe = mOpenRd && !rasN && (!lcasN || !ucasN) && !oeN;
      chk(int'(rowAddr) == mRow, "R5 rowAddr", int'(rowAddr), mRow);
      chk(int'(colAddr) == mCol, "R5 colAddr", int'(colAddr), mCol);
      chk(rdStb == mRd, "R6 rdStb", rdStb, mRd);
      chk(wrStb == mWr, "R6 wrStb", wrStb, mWr);
      chk(dqOe == expOe, "R7 dqOe", dqOe, expOe);
      if (dqOe && expValid)
        chk(mem[rowAddr] == expBit, "R5 read data", mem[rowAddr], expBit);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int bCnt = 0;

  task automatic rasOnly(int row);
    addr = AW'(row); rasN = 0; step(3);
    rasN = 1; step(2);
    bCnt = 0;
  endtask

  task automatic cbrCycle(bit upper, bit access, bit we, bit d, int col, string tag);
    if (upper) ucasN = 0; else lcasN = 0;
    step(1);
    rasN = 0; step(2);
    lcasN = 1; ucasN = 1; step(1);
    if (access) begin
      addr = AW'(col); weN = !we; din = d; oeN = we;
      if (upper) ucasN = 0; else lcasN = 0;
      step(2);
      chk(int'(rowAddr) == bCnt, tag, int'(rowAddr), bCnt);
      lcasN = 1; ucasN = 1; weN = 1; oeN = 1; step(1);
    end
    rasN = 1; step(2);
    bCnt = (bCnt + 1) % ROWS;
  endtask

  task automatic normalCyc(int row, int col, bit we, bit d, bit oeOn, int pages);
    addr = AW'(row); rasN = 0; step(2);
    for (int k = 0; k < pages; k++) begin
      addr = AW'(col + k); weN = !we; din = d; oeN = !(oeOn && !we);
      lcasN = 0; step(2);
      chk(int'(rowAddr) == row, "R9 row from pins", int'(rowAddr), row);
      if (k == 0) chk(int'(colAddr) == col, "R9 column", int'(colAddr), col);
      else chk(int'(colAddr) == col + k, "R10 page column", int'(colAddr), col + k);
      lcasN = 1; step(1);
    end
    rasN = 1; weN = 1; oeN = 1; step(2);
  endtask

  localparam int TCOL = 37;

  initial begin
    step(3);
    chk(rowAddr == '0 && colAddr == '0, "R1 reset addresses", int'(rowAddr), 0);
    chk(!rdStb && !wrStb && !dqOe, "R1 reset strobes", int'({rdStb, wrStb, dqOe}), 0);
    rstN = 1; step(2);
    cbrCycle(0, 1, 0, 0, TCOL, "R1 counter zero after reset");

    for (int i = 0; i < 8; i++) rasOnly(i * 3);
    cbrCycle(0, 1, 0, 0, TCOL, "R8 counter cleared by RAS-only");
    cbrCycle(0, 0, 0, 0, TCOL, "R2 refresh only");
    cbrCycle(1, 1, 0, 0, TCOL, "R3 upper strobe CBR");
    cbrCycle(0, 1, 0, 0, TCOL, "R2 increment");
    rasOnly(5);
    cbrCycle(1, 1, 0, 0, TCOL, "R8 mid-count clear");
    normalCyc(9, 2, 0, 1, 0, 3);
    normalCyc(9, 2, 1, 0, 0, 1);
    cbrCycle(0, 1, 0, 0, TCOL, "R9 normal access keeps counter");

    for (int p = 0; p < 2; p++) begin
      bit v;
      v = p[0];
      expValid = 0;
      rasOnly(0);
      for (int i = 0; i < ROWS; i++)
        cbrCycle(i[0], 1, 1, v, TCOL, i == 0 ? "R4 wrap to row zero" : "R5 test write row");
      chk(bCnt == 0, "R4 wrap", bCnt, 0);
      for (int i = 0; i < ROWS; i++) begin
        expValid = 1; expBit = v;
        normalCyc(i, TCOL, 0, 0, 1, 1);
        expValid = 0;
        normalCyc(i, TCOL, 1, !v, 1, 1);
      end
      expValid = 1; expBit = !v;
      for (int i = 0; i < ROWS; i++)
        cbrCycle(i[1], 1, 0, 0, TCOL, "R5 test read row");
      expValid = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule